// File: doc/BRIEF.md
# Ring Directory Routing Node

This node attaches one processor and its local cache to a one-way ring of point-to-point links, where the last node feeds the first. It has no destination field to steer by. It keeps a small directory of the pages held in its cache instead. Each directory entry records a page tag and a two-bit state for every sub-page of that page. A request arriving from the upstream neighbour is looked up in the directory. The node keeps the request when the addressed sub-page is held in a state that can serve that kind of request. Otherwise the request moves on downstream.

The cache controller has two paths into the node. It injects its own requests through a local port, and the node stamps them with its own unit number. It also keeps the directory current through a write port. A request that travels all the way round and comes back to the node that sent it, with no node having served it, is handed to the local cache marked as a miss.

Each output direction has a one-entry buffer. That buffer is a two-state machine, SLOT_EMPTY and SLOT_FULL, with these transitions:
- `push` moves SLOT_EMPTY to SLOT_FULL.
- `pop && !push` moves SLOT_FULL to SLOT_EMPTY.
- `push` while SLOT_FULL and being drained replaces the content in place.

Every cycle, the request at the upstream input is classified as one of:
- RT_IDLE: no request.
- RT_TAKE: directory hit.
- RT_RETURN: the request came back to its origin unserved.
- RT_PASS: forward downstream.

Local injection is a separate decision, RT_INJECT.

Top module: `ldr_node`

## Requirements
- R1: After reset, both outputs (`dn_valid`, `loc_valid`) are low, and both `up_ready` and `inj_ready` are high.
- R2: An accepted ring request that hits the directory appears on the local port on the next clock edge. It carries `loc_miss`=0 and unchanged address, kind and origin.
- R3: Sub-page states are encoded 0 invalid, 1 shared, 2 owned and 3 locked. Request kinds are encoded 0 read, 1 write, 2 lock and 3 probe. The serving rules are:
  - A read is served by shared or owned.
  - A write or a lock is served only by owned.
  - A probe is served only by locked.
  - An invalid sub-page serves nothing.
- R4: A request that does not hit goes out on the downstream port on the next edge, unchanged, unless it originated here. Not hitting means any of: no valid entry matches its page tag, or the sub-page state does not serve its kind.
- R5: The page tag is address bits 39:11 and the sub-page index is bits 10:7. Bits 6:0 take no part in routing.
- R6: A request whose origin equals the node's own unit number (parameter `NODE_ID`, default 3) and that does not hit is delivered locally with `loc_miss`=1. If it does hit, it is delivered with `loc_miss`=0.
- R7: Ring traffic that is going downstream has priority. `inj_ready` is low in any cycle with such traffic. Otherwise an injected request leaves downstream on the next edge, with origin equal to `NODE_ID`.
- R8: While `dn_ready` is low, the downstream packet stays valid and unchanged. `up_ready` is low for requests bound downstream, but stays high for requests bound to the local port.
- R9: A directory write takes effect for requests accepted on the following edges. Writing an entry with valid=0 removes its page.
- R10: A full buffer that is drained in the same cycle accepts a new packet, so a stalled link resumes at one packet per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| up_valid | input | 1 | Request present from upstream neighbour |
| up_ready | output | 1 | Node accepts the upstream request |
| up_addr | input | 40 | Upstream request address |
| up_kind | input | 2 | Upstream request kind |
| up_origin | input | 5 | Unit number that issued the upstream request |
| dn_valid | output | 1 | Request present for downstream neighbour |
| dn_ready | input | 1 | Downstream neighbour accepts |
| dn_addr | output | 40 | Downstream request address |
| dn_kind | output | 2 | Downstream request kind |
| dn_origin | output | 5 | Downstream request origin |
| inj_valid | input | 1 | Local cache offers a request |
| inj_ready | output | 1 | Node accepts the injected request |
| inj_addr | input | 40 | Injected request address |
| inj_kind | input | 2 | Injected request kind |
| loc_valid | output | 1 | Request delivered to local cache |
| loc_ready | input | 1 | Local cache accepts delivery |
| loc_addr | output | 40 | Delivered address |
| loc_kind | output | 2 | Delivered kind |
| loc_origin | output | 5 | Delivered origin |
| loc_miss | output | 1 | Delivered request returned unserved |
| dw_en | input | 1 | Directory write strobe |
| dw_slot | input | 3 | Directory entry written |
| dw_valid | input | 1 | New valid bit for the entry |
| dw_tag | input | 29 | New page tag for the entry |
| dw_states | input | 32 | New sub-page states, sub-page i at bits 2i+1:2i |

## Verification
The routing decision is swept over every pair of request kind and sub-page index, against one entry whose sub-page states cycle through all four codes. This separates each serving rule from its neighbours. The low address bits vary with the index, so any use of them would show as a wrong route. Tag mismatches, a removed entry and requests returning to their own origin then separate R4 from R6. Runs with injection held against pass-through traffic, and with the downstream link stalled, show the priority and the one-entry buffering.

// File: rtl/ldr_pkg.sv
package ldr_pkg;
    localparam int ADDR_W    = 40;
    localparam int LINE_LOG  = 7;                       // 128-byte sub-page
    localparam int SUBS_LOG  = 4;
    localparam int SUBS      = 1 << SUBS_LOG;
    localparam int TAG_W     = ADDR_W - LINE_LOG - SUBS_LOG;
    localparam int MAX_UNITS = 32;
    localparam int NODE_W    = $clog2(MAX_UNITS);

    typedef enum logic [1:0] {
        SP_INVALID = 2'd0,
        SP_SHARED  = 2'd1,
        SP_OWNED   = 2'd2,
        SP_LOCKED  = 2'd3
    } sp_state_e;

    typedef enum logic [1:0] {
        RQ_READ  = 2'd0,
        RQ_WRITE = 2'd1,
        RQ_LOCK  = 2'd2,
        RQ_PROBE = 2'd3
    } req_kind_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        req_kind_e         kind;
        logic [NODE_W-1:0] origin;
    } ring_pkt_t;

    typedef struct packed {
        ring_pkt_t pkt;
        logic      miss;
    } loc_pkt_t;

    // Whether a sub-page held in state s can serve a request of kind k.
    function automatic logic state_serves(req_kind_e k, sp_state_e s);
        logic ok;
        unique case (k)
            RQ_READ:  ok = (s == SP_SHARED) || (s == SP_OWNED);
            RQ_WRITE: ok = (s == SP_OWNED);
            RQ_LOCK:  ok = (s == SP_OWNED);
            RQ_PROBE: ok = (s == SP_LOCKED);
        endcase
        return ok;
    endfunction
endpackage

// File: rtl/ldr_slot.sv
module ldr_slot #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic         free,
    output logic         vld,
    output logic [W-1:0] dout
);
    typedef enum logic {SLOT_EMPTY, SLOT_FULL} slot_e;

    slot_e        st, st_nx;
    logic [W-1:0] data_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= SLOT_EMPTY;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            SLOT_EMPTY: if (push)         st_nx = SLOT_FULL;
            SLOT_FULL:  if (pop && !push) st_nx = SLOT_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (push) data_q <= din;
    end

    always_comb begin
        vld  = (st == SLOT_FULL);
        free = (st == SLOT_EMPTY) || pop;
        dout = data_q;
    end

    // R10: a push is only made into a buffer that has room this cycle
    a_r10_push_has_room: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> free);

    // R8: a held packet stays put while the consumer stalls
    a_r8_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && !pop) |=> (vld && $stable(dout)));
endmodule

// File: rtl/ldr_dir.sv
module ldr_dir
    import ldr_pkg::*;
#(
    parameter int ENTRIES = 8,
    localparam int SLOT_W = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic              wr_valid,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [SUBS*2-1:0] wr_states,
    input  logic [TAG_W-1:0]  lk_tag,
    input  logic [SUBS_LOG-1:0] lk_idx,
    input  req_kind_e         lk_kind,
    output logic              hit
);
    logic                     ent_v   [ENTRIES];
    logic [TAG_W-1:0]         ent_tag [ENTRIES];
    logic [SUBS-1:0][1:0]     ent_st  [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ent_v[g]   <= 1'b0;
                ent_tag[g] <= '0;
                ent_st[g]  <= '0;
            end else if (wr_en && (wr_slot == SLOT_W'(g))) begin
                ent_v[g]   <= wr_valid;
                ent_tag[g] <= wr_tag;
                ent_st[g]  <= wr_states;
            end
        end
    end

    logic      found;
    sp_state_e sel_state;

    always_comb begin
        found     = 1'b0;
        sel_state = SP_INVALID;
        for (int i = 0; i < ENTRIES; i++) begin
            if (!found && ent_v[i] && (ent_tag[i] == lk_tag)) begin
                found     = 1'b1;
                sel_state = sp_state_e'(ent_st[i][lk_idx]);
            end
        end
        hit = found && state_serves(lk_kind, sel_state);
    end

    // R3: an invalid sub-page never serves a request
    a_r3_invalid_never_serves: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (sel_state != SP_INVALID));
endmodule

// File: rtl/ldr_node.sv
module ldr_node
    import ldr_pkg::*;
#(
    parameter int NODE_ID     = 3,
    parameter int DIR_ENTRIES = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                up_valid,
    output logic                up_ready,
    input  logic [ADDR_W-1:0]   up_addr,
    input  logic [1:0]          up_kind,
    input  logic [NODE_W-1:0]   up_origin,
    output logic                dn_valid,
    input  logic                dn_ready,
    output logic [ADDR_W-1:0]   dn_addr,
    output logic [1:0]          dn_kind,
    output logic [NODE_W-1:0]   dn_origin,
    input  logic                inj_valid,
    output logic                inj_ready,
    input  logic [ADDR_W-1:0]   inj_addr,
    input  logic [1:0]          inj_kind,
    output logic                loc_valid,
    input  logic                loc_ready,
    output logic [ADDR_W-1:0]   loc_addr,
    output logic [1:0]          loc_kind,
    output logic [NODE_W-1:0]   loc_origin,
    output logic                loc_miss,
    input  logic                dw_en,
    input  logic [$clog2(DIR_ENTRIES)-1:0] dw_slot,
    input  logic                dw_valid,
    input  logic [TAG_W-1:0]    dw_tag,
    input  logic [SUBS*2-1:0]   dw_states
);
    localparam logic [NODE_W-1:0] SELF = NODE_W'(NODE_ID);
    localparam int RING_W = $bits(ring_pkt_t);
    localparam int LOC_W  = $bits(loc_pkt_t);

    typedef enum logic [2:0] {RT_IDLE, RT_TAKE, RT_RETURN, RT_PASS} route_e;

    ring_pkt_t up_pkt, inj_pkt, ring_din, ring_q;
    loc_pkt_t  loc_din, loc_q;
    logic      dir_hit, ring_free, loc_free, ring_push, loc_push, ring_vld, loc_vld;
    logic      to_local, inj_go;
    logic [RING_W-1:0] ring_dout;
    logic [LOC_W-1:0]  loc_dout;
    route_e    route;

    assign up_pkt  = '{addr: up_addr, kind: req_kind_e'(up_kind), origin: up_origin};
    assign inj_pkt = '{addr: inj_addr, kind: req_kind_e'(inj_kind), origin: SELF};

    ldr_dir #(.ENTRIES(DIR_ENTRIES)) u_dir (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (dw_en),
        .wr_slot   (dw_slot),
        .wr_valid  (dw_valid),
        .wr_tag    (dw_tag),
        .wr_states (dw_states),
        .lk_tag    (up_addr[ADDR_W-1 -: TAG_W]),
        .lk_idx    (up_addr[LINE_LOG +: SUBS_LOG]),
        .lk_kind   (req_kind_e'(up_kind)),
        .hit       (dir_hit)
    );

    // Route classification of the upstream request
    always_comb begin
        route = RT_IDLE;
        if (up_valid) begin
            if (dir_hit)                 route = RT_TAKE;
            else if (up_origin == SELF)  route = RT_RETURN;
            else                         route = RT_PASS;
        end
    end

    always_comb begin
        to_local  = (route == RT_TAKE) || (route == RT_RETURN);
        up_ready  = to_local ? loc_free : ring_free;
        inj_ready = ring_free && (route != RT_PASS);
        inj_go    = inj_valid && inj_ready;
        ring_push = ((route == RT_PASS) && ring_free) || inj_go;
        ring_din  = (route == RT_PASS) ? up_pkt : inj_pkt;
        loc_push  = to_local && loc_free;
        loc_din   = '{pkt: up_pkt, miss: (route == RT_RETURN)};
    end

    ldr_slot #(.W(RING_W)) u_ring_slot (
        .clk  (clk),
        .rst_n(rst_n),
        .push (ring_push),
        .din  (ring_din),
        .pop  (dn_ready),
        .free (ring_free),
        .vld  (ring_vld),
        .dout (ring_dout)
    );

    ldr_slot #(.W(LOC_W)) u_loc_slot (
        .clk  (clk),
        .rst_n(rst_n),
        .push (loc_push),
        .din  (loc_din),
        .pop  (loc_ready),
        .free (loc_free),
        .vld  (loc_vld),
        .dout (loc_dout)
    );

    assign ring_q     = ring_dout;
    assign loc_q      = loc_dout;
    assign dn_valid   = ring_vld;
    assign dn_addr    = ring_q.addr;
    assign dn_kind    = ring_q.kind;
    assign dn_origin  = ring_q.origin;
    assign loc_valid  = loc_vld;
    assign loc_addr   = loc_q.pkt.addr;
    assign loc_kind   = loc_q.pkt.kind;
    assign loc_origin = loc_q.pkt.origin;
    assign loc_miss   = loc_q.miss;

    // R2: a served request reaches the local port next cycle, not as a miss
    a_r2_take_local: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && up_ready && dir_hit) |=>
        (loc_valid && !loc_miss && loc_addr == $past(up_addr)));

    // R6: an unserved request back at its origin is returned as a miss
    a_r6_return_miss: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && up_ready && !dir_hit && up_origin == SELF) |=>
        (loc_valid && loc_miss && loc_origin == SELF));

    // R4: an unserved foreign request is forwarded unchanged
    a_r4_forward: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && up_ready && !dir_hit && up_origin != SELF) |=>
        (dn_valid && dn_addr == $past(up_addr) && dn_origin == $past(up_origin)));

    // R7: an injected request leaves stamped with this node's number
    a_r7_inject_origin: assert property (@(posedge clk) disable iff (!rst_n)
        (inj_valid && inj_ready) |=> (dn_valid && dn_origin == SELF));
endmodule

// File: tb/ldr_node_test.sv
`timescale 1ns/1ps
module ldr_node_test;
    localparam int SELF = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        up_valid = 0, dn_ready = 1, inj_valid = 0, loc_ready = 1, dw_en = 0, dw_valid = 0;
    logic        up_ready, dn_valid, inj_ready, loc_valid, loc_miss;
    logic [39:0] up_addr = '0, inj_addr = '0, dn_addr, loc_addr;
    logic [1:0]  up_kind = '0, inj_kind = '0, dn_kind, loc_kind;
    logic [4:0]  up_origin = '0, dn_origin, loc_origin;
    logic [2:0]  dw_slot = '0;
    logic [28:0] dw_tag = '0;
    logic [31:0] dw_states = '0;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    ldr_node #(.NODE_ID(SELF), .DIR_ENTRIES(8)) uut (
        .clk(clk), .rst_n(rst_n),
        .up_valid(up_valid), .up_ready(up_ready), .up_addr(up_addr), .up_kind(up_kind), .up_origin(up_origin),
        .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_addr(dn_addr), .dn_kind(dn_kind), .dn_origin(dn_origin),
        .inj_valid(inj_valid), .inj_ready(inj_ready), .inj_addr(inj_addr), .inj_kind(inj_kind),
        .loc_valid(loc_valid), .loc_ready(loc_ready), .loc_addr(loc_addr), .loc_kind(loc_kind),
        .loc_origin(loc_origin), .loc_miss(loc_miss),
        .dw_en(dw_en), .dw_slot(dw_slot), .dw_valid(dw_valid), .dw_tag(dw_tag), .dw_states(dw_states)
    );

    task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic bit serves(input int k, input int s);
        if (k == 0) return (s == 1) || (s == 2);
        if (k == 3) return (s == 3);
        return (s == 2);
    endfunction

    function automatic logic [39:0] mk(input logic [28:0] tag, input logic [3:0] idx, input logic [6:0] lo);
        return {tag, idx, lo};
    endfunction

    task automatic dir_write(input logic [2:0] slot, input logic v, input logic [28:0] tag, input logic [31:0] st);
        dw_slot = slot; dw_valid = v; dw_tag = tag; dw_states = st; dw_en = 1;
        @(negedge clk);
        dw_en = 0;
    endtask

    task automatic send_chk(input logic [39:0] a, input logic [1:0] k, input logic [4:0] o,
                            input bit exp_loc, input bit exp_miss, input string req);
        up_addr = a; up_kind = k; up_origin = o; up_valid = 1;
        #1;
        check(req, "up_ready", up_ready, 1);
        @(negedge clk);
        up_valid = 0;
        #1;
        check(req, "loc_valid", loc_valid, exp_loc);
        check(req, "dn_valid", dn_valid, !exp_loc);
        if (exp_loc) begin
            check(req, "loc_addr", loc_addr, a);
            check(req, "loc_miss", loc_miss, exp_miss);
            check(req, "loc_origin", loc_origin, o);
        end else begin
            check(req, "dn_addr", dn_addr, a);
            check(req, "dn_kind", dn_kind, k);
            check(req, "dn_origin", dn_origin, o);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [28:0] tag_a, tag_b;
        logic [31:0] cyc;
        tag_a = 29'h0ABC_1234;
        tag_b = 29'h1555_0F0F;
        repeat (3) @(negedge clk);
        #1;
        // R1 reset state
        check("R1", "dn_valid", dn_valid, 0);
        check("R1", "loc_valid", loc_valid, 0);
        check("R1", "up_ready", up_ready, 1);
        check("R1", "inj_ready", inj_ready, 1);
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // Entry 2: sub-page i holds state i%4
        for (int i = 0; i < 16; i++) cyc[2*i +: 2] = 2'(i % 4);
        dir_write(3'd2, 1'b1, tag_a, cyc);

        // R2 R3 R5: sweep every kind over every sub-page; low bits vary
        for (int k = 0; k < 4; k++) begin
            for (int i = 0; i < 16; i++) begin
                send_chk(mk(tag_a, 4'(i), 7'(i * 9 + k * 31)), 2'(k), 5'd7,
                         serves(k, i % 4), 1'b0, "R3");
            end
        end

        // R4: page tag differing in one bit is forwarded
        send_chk(mk(tag_a ^ 29'h1, 4'd1, 7'd0), 2'd0, 5'd9, 1'b0, 1'b0, "R4");
        // R5: top tag bit participates
        send_chk(mk(tag_a ^ 29'h1000_0000, 4'd2, 7'd5), 2'd0, 5'd9, 1'b0, 1'b0, "R5");

        // R9: removing the entry takes effect on the next request
        dir_write(3'd2, 1'b0, tag_a, cyc);
        send_chk(mk(tag_a, 4'd2, 7'd0), 2'd1, 5'd7, 1'b0, 1'b0, "R9");
        dir_write(3'd6, 1'b1, tag_a, 32'hFFFF_FFFF);
        send_chk(mk(tag_a, 4'd9, 7'd1), 2'd3, 5'd7, 1'b1, 1'b0, "R9");

        // R6: return to origin unserved, and served at origin
        send_chk(mk(tag_b, 4'd3, 7'd0), 2'd0, 5'(SELF), 1'b1, 1'b1, "R6");
        dir_write(3'd5, 1'b1, tag_b, 32'hAAAA_AAAA);
        send_chk(mk(tag_b, 4'd3, 7'd0), 2'd1, 5'(SELF), 1'b1, 1'b0, "R6");

        // R7: injection on an idle ring
        inj_addr = 40'h12_3456_7890; inj_kind = 2'd2; inj_valid = 1;
        #1;
        check("R7", "inj_ready idle", inj_ready, 1);
        @(negedge clk);
        inj_valid = 0;
        #1;
        check("R7", "dn_valid", dn_valid, 1);
        check("R7", "dn_origin", dn_origin, SELF);
        check("R7", "dn_addr", dn_addr, 40'h12_3456_7890);
        check("R7", "dn_kind", dn_kind, 2);

        // R7: through-traffic beats injection, then injection follows
        up_addr = mk(29'h0, 4'd0, 7'd0); up_kind = 0; up_origin = 5'd12; up_valid = 1;
        inj_addr = 40'h00_0000_0ACE; inj_kind = 1; inj_valid = 1;
        #1;
        check("R7", "inj_ready blocked", inj_ready, 0);
        @(negedge clk);
        up_valid = 0;
        #1;
        check("R7", "ring first origin", dn_origin, 12);
        check("R7", "inj_ready freed", inj_ready, 1);
        @(negedge clk);
        inj_valid = 0;
        #1;
        check("R7", "inject after", dn_addr, 40'h00_0000_0ACE);
        check("R7", "inject origin", dn_origin, SELF);

        // R7: injection allowed while ring request goes local
        up_addr = mk(tag_b, 4'd7, 7'd0); up_kind = 0; up_origin = 5'd20; up_valid = 1;
        inj_addr = 40'h00_0000_0BEE; inj_valid = 1;
        #1;
        check("R7", "inj_ready beside take", inj_ready, 1);
        @(negedge clk);
        up_valid = 0; inj_valid = 0;
        #1;
        check("R7", "take beside inject", loc_valid, 1);
        check("R7", "inject beside take", dn_addr, 40'h00_0000_0BEE);
        @(negedge clk);

        // R8 R10: downstream stall
        dn_ready = 0;
        up_addr = 40'h00_0000_1111; up_kind = 0; up_origin = 5'd8; up_valid = 1;
        @(negedge clk);
        up_addr = 40'h00_0000_2222;
        #1;
        check("R8", "dn_valid stalled", dn_valid, 1);
        check("R8", "up_ready blocked", up_ready, 0);
        @(negedge clk);
        #1;
        check("R8", "dn_addr held", dn_addr, 40'h00_0000_1111);
        // local-bound request still accepted during stall
        up_addr = mk(tag_b, 4'd4, 7'd0);
        #1;
        check("R8", "up_ready local", up_ready, 1);
        @(negedge clk);
        up_addr = 40'h00_0000_2222;
        #1;
        check("R8", "local during stall", loc_addr, mk(tag_b, 4'd4, 7'd0));
        check("R8", "dn_addr still held", dn_addr, 40'h00_0000_1111);
        dn_ready = 1;
        #1;
        check("R10", "up_ready on drain", up_ready, 1);
        @(negedge clk);
        up_valid = 0;
        #1;
        check("R10", "replaced in place", dn_addr, 40'h00_0000_2222);
        check("R10", "still valid", dn_valid, 1);
        @(negedge clk);
        #1;
        check("R10", "drained", dn_valid, 0);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule